// File: doc/BRIEF.md
# Secured Interrupt State Bitmaps

This block keeps the per-interrupt state bits for a range of shared peripheral interrupts: group, enable, pending, active, trigger mode and a two-bit non-secure access level per interrupt. Software reaches the state as 32-bit words over a single-cycle register bus that carries a secure/non-secure flag. Enable, pending and active each have a set view and a clear view. Every bitmap access passes through a per-bit permission mask. The mask depends on the security flag, the group bit of each interrupt and, for the pending and active views, a graded access level.

Interrupt input lines are synchronised into the clock domain. A rising edge on a line sets the pending latch of an interrupt configured edge-triggered. For a level-triggered interrupt, the live line level shows directly in the pending state. The block drives enable, effective pending and active vectors to the prioritisation logic further down the chip.

Top module: `spi_state_bitmaps`

## Requirements
- R1: `req_addr_i[7:4]` selects the view and `req_addr_i[3:0]` the word. View codes are: 0 group, 1 enable-set, 2 enable-clear, 3 pending-set, 4 pending-clear, 5 active-set, 6 active-clear, 7 trigger mode, 8 access level. In the one-bit views, word w bit n is interrupt ID 32w+n. In the two-bit views, word w bits [2n+1:2n] are interrupt ID 16w+n. Output vector bit i is interrupt ID 32+i.
- R2: Words that cover IDs below 32 or IDs at or above 96 read as zero and ignore writes, in every view.
- R3: In a set view, each 1 in the write data sets the state bit and each 0 leaves it unchanged. In a clear view, each 1 clears the state bit. Both views of a pair read the same state.
- R4: When `req_secure_i` is 0 and `sec_dis_i` is 0, read and write data are ANDed with a mask. The mask is the group word (group bit 1 means non-secure) ORed with any access-level grant. In all other cases the mask is all ones.
- R5: An access level of 1 or more lets non-secure accesses set pending and read the pending-set view. A level of 2 or more also allows pending-clear and reads of both active views.
- R6: Writes to the active views use only the group mask. No access-level grant applies to them.
- R7: A pending read returns the latched pending bits ORed with the synchronised line level of level-triggered interrupts. The pending output carries the same value.
- R8: The pending latch of an edge-triggered interrupt is set by a rising edge of its synchronised line. A held level, or any line of a level-triggered interrupt, sets no latch.
- R9: In the trigger-mode view, bit 2n+1 holds the edge flag of its interrupt and bit 2n reads zero. Writes update the edge flags under the R4 mask without access-level grant, and bits outside the mask keep their value.
- R10: The group view reads zero and ignores writes for non-secure accesses while security is enabled. The access-level view reads zero and ignores writes unless the access is secure and `sec_dis_i` is 0.
- R11: A line rising edge and a pending-clear of the same interrupt in the same cycle leave the latch set.
- R12: Reset clears every bitmap, the synchronisers and `rdata_o`.
- R13: `rdata_o` updates on the clock edge that accepts a read. It holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_dis_i | input | 1 | Security disabled: every access gets full access |
| irq_i | input | 64 | Interrupt lines, bit i is ID 32+i |
| req_valid_i | input | 1 | Bus access valid |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | 8 | View code [7:4], word index [3:0] |
| req_wdata_i | input | 32 | Write data |
| req_secure_i | input | 1 | Access is secure |
| rdata_o | output | 32 | Read data, one cycle after the read |
| enable_o | output | 64 | Enable state per interrupt |
| pending_o | output | 64 | Effective pending state per interrupt |
| active_o | output | 64 | Active state per interrupt |

## Verification
The masked views are driven with secure, non-secure and security-disabled accesses against a fixed group word. Results that differ between these three cases show which term of the mask is at fault. The pending views are tried with access levels 1, 2 and 3 on adjacent interrupts, which separates the "1 or more" grant from the "2 or more" grant. The active views are also tried with access levels 1, 2 and 3, which shows that active writes ignore the level. Line stimulus covers an edge interrupt whose line is pulsed and then dropped, and a level interrupt whose line is held while its pending bit is cleared. This separates the latched part of the pending state from the merged line level. A rising edge timed into the same cycle as a clear checks that the edge takes priority.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [3:0] {
    BK_GROUP  = 4'd0,
    BK_EN_SET = 4'd1,
    BK_EN_CLR = 4'd2,
    BK_PD_SET = 4'd3,
    BK_PD_CLR = 4'd4,
    BK_AC_SET = 4'd5,
    BK_AC_CLR = 4'd6,
    BK_TRIG   = 4'd7,
    BK_NSACC  = 4'd8
  } bank_e;

  typedef enum logic [1:0] {
    EXT_NONE = 2'd0,
    EXT_GE1  = 2'd1,
    EXT_GE2  = 2'd2
  } ext_e;
endpackage

// File: rtl/sbm_line_sync.sv
module sbm_line_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] line_i,
  output logic [WIDTH-1:0] line_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= line_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign line_o = stg_q[STAGES-1];
endmodule

// File: rtl/sbm_perm_mask.sv
module sbm_perm_mask import sbm_pkg::*; #(
  parameter int NUM_SPI = 64,
  localparam int NW     = NUM_SPI / 32,
  localparam int WI_W   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                   ns_gate_i,
  input  ext_e                   ext_i,
  input  logic [WI_W-1:0]        word_i,
  input  logic [NUM_SPI-1:0]     group_i,
  input  logic [2*NUM_SPI-1:0]   acc_i,
  output logic [31:0]            mask_o
);
  logic [NUM_SPI-1:0] ge1, ge2, allow;
  logic [31:0]        allow_w [NW];

  for (genvar i = 0; i < NUM_SPI; i++) begin : g_lvl
    assign ge1[i] = |acc_i[2*i +: 2];
    assign ge2[i] = acc_i[2*i+1];
  end

  always_comb begin
    case (ext_i)
      EXT_GE1: allow = group_i | ge1;
      EXT_GE2: allow = group_i | ge2;
      default: allow = group_i;
    endcase
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign allow_w[w] = allow[32*w +: 32];
  end

  assign mask_o = ns_gate_i ? allow_w[word_i] : '1;
endmodule

// File: rtl/sbm_pend_bank.sv
module sbm_pend_bank #(
  parameter int NUM_SPI = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SPI-1:0] line_i,
  input  logic [NUM_SPI-1:0] edge_i,
  input  logic [NUM_SPI-1:0] set_i,
  input  logic [NUM_SPI-1:0] clr_i,
  output logic [NUM_SPI-1:0] eff_o
);
  logic [NUM_SPI-1:0] prev_q, latch_q, rise;

  assign rise = line_i & ~prev_q & edge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= line_i;
      // edge set wins over a same-cycle clear
      latch_q <= (latch_q & ~clr_i) | set_i | rise;
    end
  end

  assign eff_o = latch_q | (line_i & ~edge_i);

  assert_rise_latches_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((latch_q & $past(rise)) == $past(rise)));

  assert_latch_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_q & ~$past(latch_q) & ~$past(rise | set_i)) == '0));

  assert_clear_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((latch_q & $past(clr_i & ~set_i & ~rise)) == '0));
endmodule

// File: rtl/spi_state_bitmaps.sv
module spi_state_bitmaps import sbm_pkg::*; #(
  parameter int NUM_SPI     = 64,
  parameter int FIRST_ID    = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sec_dis_i,
  input  logic [NUM_SPI-1:0] irq_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [31:0]        req_wdata_i,
  input  logic               req_secure_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_SPI-1:0] enable_o,
  output logic [NUM_SPI-1:0] pending_o,
  output logic [NUM_SPI-1:0] active_o
);
  localparam int NW    = NUM_SPI / 32;
  localparam int FW    = FIRST_ID / 32;
  localparam int WI_W  = (NW > 1) ? $clog2(NW) : 1;
  localparam int IDX_W = ADDR_W - 4;

  bank_e            bank;
  logic [IDX_W-1:0] idx;
  int               w_n;
  logic             cur_ok, half, ns_gate, we;
  logic [WI_W-1:0]  cur_w;
  ext_e             ext;
  logic [31:0]      mask, wm, tnew, tmask, rd_val, hmask;
  logic [15:0]      tcomp, texp_src;

  logic [31:0] group_q [NW];
  logic [31:0] en_q    [NW];
  logic [31:0] act_q   [NW];
  logic [31:0] edge_q  [NW];
  logic [31:0] acc_q   [2*NW];
  logic [31:0] pend_w  [NW];

  logic [NUM_SPI-1:0]   group_v, edge_v, line_sync, pd_set, pd_clr, pend_eff;
  logic [2*NUM_SPI-1:0] acc_v;

  assign bank    = bank_e'(req_addr_i[ADDR_W-1 -: 4]);
  assign idx     = req_addr_i[IDX_W-1:0];
  assign half    = idx[0];
  assign ns_gate = !req_secure_i && !sec_dis_i;
  assign we      = req_valid_i && req_write_i && cur_ok;

  // word decode: two-bit views pack 16 IDs per word
  always_comb begin
    w_n    = (bank == BK_TRIG || bank == BK_NSACC) ? int'(idx) / 2 : int'(idx);
    cur_ok = (w_n >= FW) && (w_n < FW + NW);
    cur_w  = cur_ok ? WI_W'(w_n - FW) : '0;
  end

  always_comb begin
    case (bank)
      BK_PD_SET:            ext = EXT_GE1;
      BK_PD_CLR:            ext = EXT_GE2;
      BK_AC_SET, BK_AC_CLR: ext = req_write_i ? EXT_NONE : EXT_GE2;
      default:              ext = EXT_NONE;
    endcase
  end

  for (genvar w = 0; w < NW; w++) begin : g_flat
    assign group_v[32*w +: 32]  = group_q[w];
    assign edge_v[32*w +: 32]   = edge_q[w];
    assign enable_o[32*w +: 32] = en_q[w];
    assign active_o[32*w +: 32] = act_q[w];
    assign pend_w[w]            = pend_eff[32*w +: 32];
  end

  for (genvar j = 0; j < 2*NW; j++) begin : g_acc
    assign acc_v[32*j +: 32] = acc_q[j];
  end

  sbm_perm_mask #(.NUM_SPI(NUM_SPI)) u_mask (
    .ns_gate_i (ns_gate),
    .ext_i     (ext),
    .word_i    (cur_w),
    .group_i   (group_v),
    .acc_i     (acc_v),
    .mask_o    (mask)
  );

  sbm_line_sync #(.WIDTH(NUM_SPI), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (irq_i),
    .line_o (line_sync)
  );

  assign wm    = req_wdata_i & mask;
  assign hmask = half ? 32'hFFFF_0000 : 32'h0000_FFFF;
  assign tmask = mask & hmask;

  always_comb begin
    for (int k = 0; k < 16; k++) tcomp[k] = req_wdata_i[2*k+1];
    tnew = half ? {tcomp, 16'h0} : {16'h0, tcomp};
  end

  always_comb begin
    pd_set = '0;
    pd_clr = '0;
    for (int w = 0; w < NW; w++) begin
      if (we && cur_w == WI_W'(w)) begin
        if (bank == BK_PD_SET) pd_set[32*w +: 32] = wm;
        if (bank == BK_PD_CLR) pd_clr[32*w +: 32] = wm;
      end
    end
  end

  sbm_pend_bank #(.NUM_SPI(NUM_SPI)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_sync),
    .edge_i (edge_v),
    .set_i  (pd_set),
    .clr_i  (pd_clr),
    .eff_o  (pend_eff)
  );

  assign pending_o = pend_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NW; w++) begin
        group_q[w] <= '0;
        en_q[w]    <= '0;
        act_q[w]   <= '0;
        edge_q[w]  <= '0;
      end
      for (int j = 0; j < 2*NW; j++) acc_q[j] <= '0;
    end else if (we) begin
      case (bank)
        BK_GROUP:  if (!ns_gate) group_q[cur_w] <= req_wdata_i;
        BK_EN_SET: en_q[cur_w]  <= en_q[cur_w] | wm;
        BK_EN_CLR: en_q[cur_w]  <= en_q[cur_w] & ~wm;
        BK_AC_SET: act_q[cur_w] <= act_q[cur_w] | wm;
        BK_AC_CLR: act_q[cur_w] <= act_q[cur_w] & ~wm;
        BK_TRIG:   edge_q[cur_w] <= (edge_q[cur_w] & ~tmask) | (tnew & tmask);
        BK_NSACC:  if (req_secure_i && !sec_dis_i) acc_q[{cur_w, half}] <= req_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val   = '0;
    texp_src = half ? (edge_q[cur_w][31:16] & mask[31:16]) : (edge_q[cur_w][15:0] & mask[15:0]);
    if (cur_ok) begin
      case (bank)
        BK_GROUP:             rd_val = ns_gate ? '0 : group_q[cur_w];
        BK_EN_SET, BK_EN_CLR: rd_val = en_q[cur_w] & mask;
        BK_PD_SET, BK_PD_CLR: rd_val = pend_w[cur_w] & mask;
        BK_AC_SET, BK_AC_CLR: rd_val = act_q[cur_w] & mask;
        BK_TRIG:   for (int k = 0; k < 16; k++) rd_val[2*k+1] = texp_src[k];
        BK_NSACC:  rd_val = (req_secure_i && !sec_dis_i) ? acc_q[{cur_w, half}] : '0;
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rdata_o <= '0;
    else if (req_valid_i && !req_write_i) rdata_o <= rd_val;
  end

  assert_rdata_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> $stable(rdata_o));

  assert_low_word_raz_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i[ADDR_W-1 -: 4] <= 4'd6 && int'(idx) < FW)
    |=> (rdata_o == '0));

  assert_bad_word_keeps_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !cur_ok) |=> $stable(enable_o) && $stable(active_o));

  assert_ns_group_ro_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !req_secure_i && !sec_dis_i && bank == BK_GROUP)
    |=> $stable(group_v));
endmodule

// File: tb/spi_state_bitmaps_test.sv
module spi_state_bitmaps_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sec_dis_i = 1'b0;
  logic [63:0] irq_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        req_secure_i = 1'b1;
  logic [31:0] rdata_o;
  logic [63:0] enable_o, pending_o, active_o;

  int n_chk = 0;
  int n_fail = 0;
  logic        rd_seen = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  spi_state_bitmaps uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sec_dis_i(sec_dis_i), .irq_i(irq_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_secure_i(req_secure_i), .rdata_o(rdata_o),
    .enable_o(enable_o), .pending_o(pending_o), .active_o(active_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] adr(input int bk, input int ix);
    return {bk[3:0], ix[3:0]};
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic s);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d; req_secure_i = s;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic s, input logic [31:0] e, input string tag);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a; req_secure_i = s;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: a read accepted at a rising edge is compared at the next falling edge
  always @(posedge clk_i) rd_seen = rst_ni && req_valid_i && !req_write_i;

  always @(negedge clk_i) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R13 unexpected read result actual=%h expected=none", rdata_o);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({32'h0, rdata_o}, {32'h0, e}, t);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst_ni = 1'b1;
    wait_cyc(1);
    // R12 reset state
    chk(enable_o, 64'h0, "R12 enable after reset");
    chk(pending_o, 64'h0, "R12 pending after reset");
    chk(active_o, 64'h0, "R12 active after reset");
    chk({32'h0, rdata_o}, 64'h0, "R12 rdata after reset");

    // R3 set and clear views
    bus_wr(adr(1, 1), 32'h0000_00F0, 1'b1);
    bus_rd(adr(1, 1), 1'b1, 32'h0000_00F0, "R3 enable set view");
    bus_wr(adr(2, 1), 32'h0000_0030, 1'b1);
    bus_rd(adr(2, 1), 1'b1, 32'h0000_00C0, "R3 enable clear view");
    chk(enable_o, 64'h0000_0000_0000_00C0, "R3 enable vector");

    // R1 second word maps to ID 64 = output bit 32
    bus_wr(adr(1, 2), 32'h0000_0001, 1'b1);
    chk(enable_o, 64'h0000_0001_0000_00C0, "R1 word 2 bit 0 is ID 64");
    bus_wr(adr(2, 2), 32'h0000_0001, 1'b1);

    // R2 out-of-range words
    bus_wr(adr(1, 0), 32'hFFFF_FFFF, 1'b1);
    bus_wr(adr(1, 3), 32'hFFFF_FFFF, 1'b1);
    bus_wr(adr(5, 0), 32'hFFFF_FFFF, 1'b1);
    chk(enable_o, 64'h0000_0000_0000_00C0, "R2 enable unchanged");
    chk(active_o, 64'h0, "R2 active unchanged");
    bus_rd(adr(1, 0), 1'b1, 32'h0, "R2 word 0 reads zero");
    bus_rd(adr(1, 3), 1'b1, 32'h0, "R2 word 3 reads zero");
    bus_rd(adr(7, 1), 1'b1, 32'h0, "R2 trigger word for IDs 16-31 reads zero");

    // R4 permission mask by group
    bus_wr(adr(0, 1), 32'h0000_FF00, 1'b1);
    bus_wr(adr(1, 1), 32'hFFFF_FFFF, 1'b0);
    chk(enable_o, 64'h0000_0000_0000_FFC0, "R4 non-secure set limited to group");
    bus_rd(adr(2, 1), 1'b0, 32'h0000_FF00, "R4 non-secure read masked");
    bus_rd(adr(1, 1), 1'b1, 32'h0000_FFC0, "R4 secure read full");
    // R10 group register guarded
    bus_rd(adr(0, 1), 1'b0, 32'h0, "R10 non-secure group read zero");
    bus_wr(adr(0, 1), 32'h0, 1'b0);
    bus_rd(adr(0, 1), 1'b1, 32'h0000_FF00, "R10 non-secure group write ignored");
    // R4 security disabled
    sec_dis_i = 1'b1;
    bus_rd(adr(1, 1), 1'b0, 32'h0000_FFC0, "R4 security disabled full mask");

    // R10 access-level view with security disabled
    bus_wr(adr(8, 2), 32'h0000_0055, 1'b1);
    bus_rd(adr(8, 2), 1'b1, 32'h0, "R10 access view zero when security disabled");
    sec_dis_i = 1'b0;
    bus_rd(adr(8, 2), 1'b1, 32'h0, "R10 write ignored when security disabled");
    // ID32 level 1, ID33 level 2, ID34 level 3
    bus_wr(adr(8, 2), 32'h0000_0039, 1'b1);
    bus_rd(adr(8, 2), 1'b1, 32'h0000_0039, "R10 secure access view");
    bus_rd(adr(8, 2), 1'b0, 32'h0, "R10 non-secure access view zero");
    bus_wr(adr(8, 2), 32'h0, 1'b0);
    bus_rd(adr(8, 2), 1'b1, 32'h0000_0039, "R10 non-secure access write ignored");

    // R5 graded pending access
    bus_wr(adr(3, 1), 32'h0000_000F, 1'b0);
    chk(pending_o, 64'h7, "R5 level>=1 grants set-pending");
    bus_rd(adr(3, 1), 1'b0, 32'h0000_0007, "R5 non-secure pending-set read");
    bus_wr(adr(4, 1), 32'h0000_0007, 1'b0);
    bus_rd(adr(4, 1), 1'b1, 32'h0000_0001, "R5 level>=2 grants clear-pending");

    // R6 active writes ignore access level, reads use level>=2
    bus_wr(adr(5, 1), 32'h0000_0007, 1'b1);
    bus_wr(adr(5, 1), 32'h0000_0008, 1'b0);
    bus_rd(adr(5, 1), 1'b0, 32'h0000_0006, "R6 active read uses level>=2");
    bus_wr(adr(6, 1), 32'h0000_0006, 1'b0);
    bus_rd(adr(6, 1), 1'b1, 32'h0000_0007, "R6 non-secure active clear ignored");
    chk(active_o, 64'h7, "R6 active vector");

    // R9 trigger mode: edges for ID36, ID37; bit 8 ignored
    bus_wr(adr(7, 2), 32'h0000_0B00, 1'b1);
    bus_rd(adr(7, 2), 1'b1, 32'h0000_0A00, "R9 trigger expand");
    bus_wr(adr(7, 2), 32'h0002_0200, 1'b0);
    bus_rd(adr(7, 2), 1'b1, 32'h0002_0A00, "R9 masked trigger write");
    bus_rd(adr(7, 2), 1'b0, 32'h0002_0000, "R9 non-secure trigger read masked");
    bus_rd(adr(7, 3), 1'b1, 32'h0, "R9 upper half word empty");

    // R8 edge latch on ID36 (bit 4)
    @(negedge clk_i); irq_i[4] = 1'b1;
    wait_cyc(4);
    chk(pending_o, 64'h11, "R8 rising edge latches");
    @(negedge clk_i); irq_i[4] = 1'b0;
    wait_cyc(4);
    chk(pending_o, 64'h11, "R8 latch holds after line drops");
    // R7 level merge on ID38 (bit 6)
    @(negedge clk_i); irq_i[6] = 1'b1;
    wait_cyc(4);
    chk(pending_o, 64'h51, "R7 level line shows as pending");
    bus_rd(adr(3, 1), 1'b1, 32'h0000_0051, "R7 pending read merges level");
    bus_wr(adr(4, 1), 32'h0000_0050, 1'b1);
    bus_rd(adr(4, 1), 1'b1, 32'h0000_0041, "R7 level stays while line high");
    @(negedge clk_i); irq_i[6] = 1'b0;
    wait_cyc(4);
    bus_rd(adr(3, 1), 1'b1, 32'h0000_0001, "R8 level line left no latch");

    // R11 edge on ID37 (bit 5) coincides with a pending-clear
    @(negedge clk_i); irq_i[5] = 1'b1;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = adr(4, 1);
    req_wdata_i = 32'h0000_0020; req_secure_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0;
    chk(pending_o, 64'h21, "R11 edge wins over same-cycle clear");
    bus_wr(adr(4, 1), 32'h0000_0020, 1'b1);
    chk(pending_o, 64'h01, "R11 later clear with line held high");

    // R13 read data holds across a write
    bus_rd(adr(1, 1), 1'b1, 32'h0000_FFC0, "R13 read result");
    bus_wr(adr(2, 1), 32'h0000_0040, 1'b1);
    wait_cyc(2);
    chk({32'h0, rdata_o}, 64'h0000_FFC0, "R13 rdata holds after write");
    chk(enable_o, 64'h0000_0000_0000_FF80, "R3 final enable vector");

    wait_cyc(2);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R13 missing read results actual=%0d expected=0", exp_q.size());
    end
    report();
    $finish;
  end
endmodule